// File: doc/BRIEF.md
# Multi-Rate Clock and Reset Sequencer

This block takes one fast tick clock and derives three related clocks from it: a base clock, a clock at twice that rate and a clock at four times that rate. One base period lasts eight fast ticks. All three clocks start high at the beginning of each base period. They are packed into a single control vector together with an active-high reset bit, and downstream logic uses that vector as its clock and reset bundle.

The block counts base periods. It holds the reset bit asserted until the count exceeds a reset threshold and then clears it. It keeps a per-thread stop mask at all ones until the count exceeds a longer run threshold and then clears it, which lets the execution threads start. Both releases happen once. Only the asynchronous active-low reset or the synchronous restart input brings them back.

Top module: `clkseq_top`

## Requirements
- R1: While `rst_n` is low, and on the first tick after it rises, `ctrl_vec` is 0x3C, `stop_mask` is all ones and `base_cycle` is 1.
- R2: The 3-bit clock code {ctrl_vec[5], ctrl_vec[3], ctrl_vec[2]} (base, 2x, 4x) falls by one on every fast tick and goes from 0 back to 7. Its value is 7 minus the phase index (tick count modulo 8).
- R3: ctrl_vec[1:0] are always 0.
- R4: `base_cycle` rises by one on the tick where the clock code goes from 0 to 7. On every other tick it holds its value.
- R5: ctrl_vec[4] (reset) clears on the fast tick after `base_cycle` first becomes greater than `RST_CYCLES`.
- R6: Once cleared, ctrl_vec[4] stays 0 until `rst_n` or `restart` is asserted.
- R7: Clearing the reset bit has no effect on the clock bits, which keep the R2 sequence without a break.
- R8: `stop_mask` clears to all zeros on the fast tick after `base_cycle` first becomes greater than `RUN_CYCLES`. After that it stays zero until `rst_n` or `restart` is asserted.
- R9: `restart` is sampled high on a tick edge. After that edge the outputs are phase 0 (code 7), reset asserted (`ctrl_vec` 0x3C), `base_cycle` 1 and `stop_mask` all ones.
- R10: `base_cycle` wraps modulo 2^`CNT_W`. A wrap does not re-assert reset or the stop mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| restart | input | 1 | Synchronous master restart, active high |
| ctrl_vec | output | 6 | [5] base clock, [4] reset, [3] 2x clock, [2] 4x clock, [1:0] zero |
| stop_mask | output | THREADS | Per-thread stop mask, all ones while the threads are held |
| base_cycle | output | CNT_W | Base-cycle counter, starts at 1 |

## Verification
The bench builds two copies of the block. The first uses the defaults: thresholds 10 and 200 and a 16-bit counter, which checks both releases at their nominal base counts. The second uses thresholds 2 and 5 with a 4-bit counter. That makes the counter wrap several times within the run, so it checks that a wrap neither re-asserts reset nor sets the stop mask again. A mid-run restart is applied to both copies, and both releases must then happen a second time on schedule.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int PHASES    = 8;
  localparam int PH_W      = $clog2(PHASES);
  localparam int VEC_W     = 6;
  localparam int POS_BASE  = 5;
  localparam int POS_RST   = 4;
  localparam int POS_2X    = 3;
  localparam int POS_4X    = 2;
  typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/clkseq_phase.sv
module clkseq_phase
  import clkseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  output logic [PH_W-1:0] clk_code,
  output logic           wrap
);
  phase_t ph_q, ph_d;

  always_comb begin
    if (restart) ph_d = '0;
    else         ph_d = ph_q + phase_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // Code counts down while the phase counts up: each bit is high in the first half of its period
  for (genvar i = 0; i < PH_W; i++) begin : g_bit
    assign clk_code[i] = ~ph_q[i];
  end

  assign wrap = (ph_q == phase_t'(PHASES - 1));
endmodule

// File: rtl/clkseq_counter.sv
module clkseq_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             inc_en,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] START = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = restart | inc_en;

  always_comb begin
    if (restart) cnt_d = START;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= START;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/clkseq_release.sv
module clkseq_release #(
  parameter int CNT_W = 16,
  parameter int LIMIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] count,
  output logic             held
);
  localparam logic [CNT_W:0] LIM = (CNT_W+1)'(LIMIT);
  logic held_q, held_d, held_en, past_limit;

  assign past_limit = ({1'b0, count} > LIM);
  assign held_en    = restart | (held_q & past_limit);

  always_comb begin
    if (restart) held_d = 1'b1;
    else         held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b1;
    else if (held_en) held_q <= held_d;
  end

  assign held = held_q;
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
  import clkseq_pkg::*;
#(
  parameter int THREADS    = 2,
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 10,
  parameter int RUN_CYCLES = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  output logic [VEC_W-1:0]   ctrl_vec,
  output logic [THREADS-1:0] stop_mask,
  output logic [CNT_W-1:0]   base_cycle
);
  logic [PH_W-1:0]  code;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic             rst_held, stop_held;

  clkseq_phase u_phase (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .clk_code(code), .wrap(wrap)
  );

  clkseq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .inc_en(wrap), .count(cnt)
  );

  clkseq_release #(.CNT_W(CNT_W), .LIMIT(RST_CYCLES)) u_rst_rel (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .count(cnt), .held(rst_held)
  );

  clkseq_release #(.CNT_W(CNT_W), .LIMIT(RUN_CYCLES)) u_run_rel (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .count(cnt), .held(stop_held)
  );

  always_comb begin
    ctrl_vec           = '0;
    ctrl_vec[POS_BASE] = code[2];
    ctrl_vec[POS_2X]   = code[1];
    ctrl_vec[POS_4X]   = code[0];
    ctrl_vec[POS_RST]  = rst_held;
  end

  assign stop_mask  = {THREADS{stop_held}};
  assign base_cycle = cnt;
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk #(
  parameter int THREADS = 2,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               restart,
  input logic [5:0]         ctrl_vec,
  input logic [THREADS-1:0] stop_mask,
  input logic [CNT_W-1:0]   base_cycle
);
  logic [2:0] code;
  assign code = {ctrl_vec[5], ctrl_vec[3], ctrl_vec[2]};

  p_code_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (code == 3'($past(code) - 3'd1)));

  p_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_vec[1:0] == 2'b00);

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && code != 3'd0) |=> $stable(base_cycle));

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && code == 3'd0) |=> (base_cycle == CNT_W'($past(base_cycle) + 1'b1)));

  p_rst_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !ctrl_vec[4]) |=> !ctrl_vec[4]);

  p_mask_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && stop_mask == '0) |=> (stop_mask == '0));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ctrl_vec == 6'h3C && stop_mask == {THREADS{1'b1}} && base_cycle == CNT_W'(1)));
endmodule

bind clkseq_top clkseq_chk #(.THREADS(THREADS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart),
  .ctrl_vec(ctrl_vec), .stop_mask(stop_mask), .base_cycle(base_cycle)
);

// File: tb/clkseq_top_tb.sv
`timescale 1ns/1ps
module clkseq_top_tb;
  localparam int TH = 2;
  localparam int CWA = 16, RA = 10, UA = 200;
  localparam int CWB = 4,  RB = 2,  UB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]     vec_a, vec_b;
  logic [TH-1:0]  msk_a, msk_b;
  logic [CWA-1:0] cnt_a;
  logic [CWB-1:0] cnt_b;

  clkseq_top #(.THREADS(TH), .CNT_W(CWA), .RST_CYCLES(RA), .RUN_CYCLES(UA)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .ctrl_vec(vec_a), .stop_mask(msk_a), .base_cycle(cnt_a));

  clkseq_top #(.THREADS(TH), .CNT_W(CWB), .RST_CYCLES(RB), .RUN_CYCLES(UB)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .ctrl_vec(vec_b), .stop_mask(msk_b), .base_cycle(cnt_b));

  int vectors = 0, errors = 0;
  bit done = 0;

  // Behavioural reference: [0] default copy, [1] small copy
  int m_tick[2], m_cyc[2], m_rst[2], m_stop[2];
  int lim_r[2] = '{RA, RB};
  int lim_u[2] = '{UA, UB};
  int modv[2]  = '{1 << CWA, 1 << CWB};

  task automatic model_init();
    for (int k = 0; k < 2; k++) begin
      m_tick[k] = 0; m_cyc[k] = 1; m_rst[k] = 1; m_stop[k] = 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || restart) model_init();
    else begin
      for (int k = 0; k < 2; k++) begin
        if (m_cyc[k] > lim_r[k]) m_rst[k] = 0;
        if (m_cyc[k] > lim_u[k]) m_stop[k] = 0;
        if ((m_tick[k] % 8) == 7) m_cyc[k] = (m_cyc[k] + 1) % modv[k];
        m_tick[k] = m_tick[k] + 1;
      end
    end
  end

  task automatic compare(int k, logic [5:0] v, logic [TH-1:0] m, int c, string tag);
    int code;
    logic [2:0] got;
    code = 7 - (m_tick[k] % 8);
    got  = {v[5], v[3], v[2]};
    vectors++;
    if (int'(got) != code) begin
      errors++; $display("FAIL R2/R7 %s clock code got %0d exp %0d", tag, got, code);
    end
    if (v[1:0] != 2'b00) begin
      errors++; $display("FAIL R3 %s spare bits got %b exp 00", tag, v[1:0]);
    end
    if (int'(v[4]) != m_rst[k]) begin
      errors++; $display("FAIL R5/R6 %s reset bit got %0d exp %0d", tag, v[4], m_rst[k]);
    end
    if (m != (m_stop[k] != 0 ? {TH{1'b1}} : {TH{1'b0}})) begin
      errors++; $display("FAIL R8 %s stop mask got %b exp all %0d", tag, m, m_stop[k]);
    end
    if (c != m_cyc[k]) begin
      errors++; $display("FAIL R4/R10 %s count got %0d exp %0d", tag, c, m_cyc[k]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compare(0, vec_a, msk_a, int'(cnt_a), "dflt");
      compare(1, vec_b, msk_b, int'(cnt_b), "small");
    end
  end

  task automatic check_reset_state(string req);
    vectors++;
    if (vec_a != 6'h3C || msk_a != {TH{1'b1}} || cnt_a != CWA'(1)) begin
      errors++; $display("FAIL %s dflt vec %h mask %b cnt %0d exp 3c/11/1", req, vec_a, msk_a, cnt_a);
    end
    vectors++;
    if (vec_b != 6'h3C || msk_b != {TH{1'b1}} || cnt_b != CWB'(1)) begin
      errors++; $display("FAIL %s small vec %h mask %b cnt %0d exp 3c/11/1", req, vec_b, msk_b, cnt_b);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    // R5 R8 R10: run past both releases and several small-counter wraps
    repeat (1803) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check_reset_state("R9");
    // second release sequence after restart
    repeat (1700) @(negedge clk);
    done = 1;
    summary();
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired, exp completion");
    summary();
  end
endmodule